// File: doc/BRIEF.md
# Programmable IDE PIO Cycle Timer

This block shapes the command strobes of programmed-I/O transfers on a local-bus IDE interface. Each transfer request drives either the read strobe or the write strobe low for a programmed number of bus clocks. The strobe then stays high for a programmed recovery time before the block reports the transfer done. Two timing bytes hold the programmed values, and a control byte decides which of the two governs a given transfer. In primary-only mode the master/slave bit selects the timing byte. In dual-port mode the channel bit selects it.

Software reaches the block through a four-byte register window. Offset 0 is timing byte A, offset 1 is a read-only configuration/identity byte, offset 2 is timing byte B and offset 3 is the control byte. In a timing byte, the low nibble gives the active time and the high nibble gives the recovery time. Both are stored as complements of the clock count, so a larger field value gives a shorter time. The sequencer captures the timing of the selected byte when it accepts a request. Later register writes therefore only affect the next transfer.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset, timing bytes A and B read 0x00 and the control byte reads 0x0F. With these values a transfer has 17 active and 15 recovery clocks.
- R2: A write to offset 0, 2 or 3 updates timing byte A, timing byte B or the control byte. A read request returns the addressed byte on `reg_rdata` one clock later.
- R3: Offset 1 reads as {ID_CODE[3:0], 1, `strap_slow_bus`, `strap_base_hi`, `strap_port_pri`}, from bit 7 down to bit 0. Writes to offset 1 change nothing.
- R4: The strobe stays low for 17 minus the low nibble of the selected timing byte, which is 2 to 17 clocks. A transfer with `xfer_rd`=1 uses `rd_strobe_n` and one with `xfer_rd`=0 uses `wr_strobe_n`. The unused strobe stays high, and the two strobes are never low together.
- R5: After the strobe rises, recovery lasts 15 minus the high nibble of the selected byte, in clocks. High nibbles 14 and 15 are clamped to 2 clocks.
- R6: `busy` is high from the clock after a request is accepted until the end of recovery. `done` is high for exactly the last recovery clock. A request raised while `busy` is high is ignored.
- R7: When control bit 0 is 1, `xfer_dev`=0 selects timing byte A and `xfer_dev`=1 selects timing byte B, and `xfer_chan` has no effect.
- R8: When control bit 0 is 0, `xfer_chan`=0 selects timing byte A and `xfer_chan`=1 selects timing byte B, and `xfer_dev` has no effect.
- R9: A timing byte written during a transfer leaves the current strobe and recovery lengths unchanged. The new value applies from the next transfer.
- R10: `buf_en` equals control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 2 | Register offset in the window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one clock after `reg_rd` |
| strap_slow_bus | input | 1 | Bus-speed strap (1 = 33 MHz or slower) |
| strap_base_hi | input | 1 | Decoded-window strap |
| strap_port_pri | input | 1 | IDE port address strap |
| xfer_req | input | 1 | Transfer request |
| xfer_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| xfer_chan | input | 1 | Channel of the addressed drive |
| xfer_dev | input | 1 | 0 = master, 1 = slave |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last recovery clock |
| buf_en | output | 1 | Read-ahead / post-write buffering enable |

## Verification
Two things can happen in the same cycle while a transfer is in progress. A write can update the very timing byte that governs the transfer, and a new request can arrive while the sequencer is busy. The bench provokes both on the first active clock of a transfer. The write changes the selected byte to very different counts, and `xfer_req` is pulsed at the same time. The check passes if the measured strobe and recovery lengths still match the old byte, `busy` stays low after `done`, and the following transfer shows the new lengths.

// File: rtl/ide_tim_pkg.sv
package ide_tim_pkg;
    localparam int DATA_W   = 8;
    localparam int CNT_W    = 5;
    localparam int ACT_BIAS = 17;
    localparam int REC_BIAS = 15;
    localparam int MIN_CLK  = 2;
    localparam int N_TIMERS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_REC  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [DATA_W-1:0] tim_a;
        logic [DATA_W-1:0] tim_b;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] rdata;
    } regs_s;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rec;
        logic             rd;
    } seq_s;
endpackage

// File: rtl/ide_tim_regs.sv
module ide_tim_regs
    import ide_tim_pkg::*;
#(
    parameter logic [3:0] ID_CODE = 4'b1010,
    parameter logic [7:0] CTRL_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              slow_bus,
    input  logic              base_hi,
    input  logic              port_pri,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] tim_a,
    output logic [DATA_W-1:0] tim_b,
    output logic [DATA_W-1:0] ctrl
);
    regs_s r_d, r_q;
    logic [DATA_W-1:0] cfg_val;

    assign cfg_val = {ID_CODE, 1'b1, slow_bus, base_hi, port_pri};

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                2'd0:    r_d.tim_a = wdata;
                2'd2:    r_d.tim_b = wdata;
                2'd3:    r_d.ctrl  = wdata;
                default: ;
            endcase
        end
        if (rd) begin
            case (addr)
                2'd0:    r_d.rdata = r_q.tim_a;
                2'd1:    r_d.rdata = cfg_val;
                2'd2:    r_d.rdata = r_q.tim_b;
                default: r_d.rdata = r_q.ctrl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tim_a <= '0;
            r_q.tim_b <= '0;
            r_q.ctrl  <= CTRL_RST;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;
    assign tim_a = r_q.tim_a;
    assign tim_b = r_q.tim_b;
    assign ctrl  = r_q.ctrl;

    // R2
    tim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> ($stable(r_q.tim_a) && $stable(r_q.tim_b) && $stable(r_q.ctrl)));

    // R3
    cfg_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr) && $past(addr) == 2'd1) |-> ($stable(r_q.tim_a) && $stable(r_q.tim_b) && $stable(r_q.ctrl)));
endmodule

// File: rtl/ide_tim_decode.sv
module ide_tim_decode
    import ide_tim_pkg::*;
(
    input  logic [DATA_W-1:0] tim,
    output logic [CNT_W-1:0]  act_clks,
    output logic [CNT_W-1:0]  rec_clks
);
    localparam logic [3:0] REC_FIELD_MAX = 4'(REC_BIAS - MIN_CLK);

    always_comb begin
        act_clks = CNT_W'(ACT_BIAS) - {1'b0, tim[3:0]};
        if (tim[7:4] > REC_FIELD_MAX)
            rec_clks = CNT_W'(MIN_CLK);
        else
            rec_clks = CNT_W'(REC_BIAS) - {1'b0, tim[7:4]};
    end
endmodule

// File: rtl/ide_tim_seq.sv
module ide_tim_seq
    import ide_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rd_dir,
    input  logic [CNT_W-1:0] act_clks,
    input  logic [CNT_W-1:0] rec_clks,
    output logic             rd_n,
    output logic             wr_n,
    output logic             busy,
    output logic             done
);
    seq_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.st  = ST_ACT;
                    s_d.cnt = act_clks - CNT_W'(1);
                    s_d.rec = rec_clks;
                    s_d.rd  = rd_dir;
                end
            end
            ST_ACT: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_REC;
                    s_d.cnt = s_q.rec - CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_REC: begin
                if (s_q.cnt == '0) s_d.st = ST_IDLE;
                else               s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.cnt <= '0;
            s_q.rec <= '0;
            s_q.rd  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_n = !(s_q.st == ST_ACT && s_q.rd);
    assign wr_n = !(s_q.st == ST_ACT && !s_q.rd);
    assign busy = (s_q.st != ST_IDLE);
    assign done = (s_q.st == ST_REC) && (s_q.cnt == '0);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R9
    latched_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE && $past(s_q.st) != ST_IDLE) |-> $stable(s_q.rec));
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
    import ide_tim_pkg::*;
#(
    parameter logic [3:0] ID_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              strap_slow_bus,
    input  logic              strap_base_hi,
    input  logic              strap_port_pri,
    input  logic              xfer_req,
    input  logic              xfer_rd,
    input  logic              xfer_chan,
    input  logic              xfer_dev,
    output logic              rd_strobe_n,
    output logic              wr_strobe_n,
    output logic              busy,
    output logic              done,
    output logic              buf_en
);
    logic [DATA_W-1:0] tim_a, tim_b, ctrl;
    logic [DATA_W-1:0] tim_arr [N_TIMERS];
    logic [CNT_W-1:0]  act_arr [N_TIMERS];
    logic [CNT_W-1:0]  rec_arr [N_TIMERS];
    logic              sel;

    ide_tim_regs #(.ID_CODE(ID_CODE)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .slow_bus(strap_slow_bus), .base_hi(strap_base_hi),
        .port_pri(strap_port_pri), .rdata(reg_rdata), .tim_a(tim_a),
        .tim_b(tim_b), .ctrl(ctrl)
    );

    assign tim_arr[0] = tim_a;
    assign tim_arr[1] = tim_b;

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_dec
        ide_tim_decode dec_i (
            .tim(tim_arr[g]), .act_clks(act_arr[g]), .rec_clks(rec_arr[g])
        );
    end

    assign sel = ctrl[0] ? xfer_dev : xfer_chan;

    ide_tim_seq seq_i (
        .clk(clk), .rst_n(rst_n), .req(xfer_req), .rd_dir(xfer_rd),
        .act_clks(act_arr[sel]), .rec_clks(rec_arr[sel]),
        .rd_n(rd_strobe_n), .wr_n(wr_strobe_n), .busy(busy), .done(done)
    );

    assign buf_en = ctrl[7];

    // R4
    act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_arr[sel] >= CNT_W'(MIN_CLK)) && (act_arr[sel] <= CNT_W'(ACT_BIAS)));

    // R5
    rec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_arr[sel] >= CNT_W'(MIN_CLK)) && (rec_arr[sel] <= CNT_W'(REC_BIAS)));

    // R6
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/ide_pio_timer_tb.sv
`timescale 1ns/1ps
module ide_pio_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       xfer_req = 1'b0, xfer_rd = 1'b0, xfer_chan = 1'b0, xfer_dev = 1'b0;
    logic       rd_strobe_n, wr_strobe_n, busy, done, buf_en;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    ide_pio_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .strap_slow_bus(1'b1), .strap_base_hi(1'b0), .strap_port_pri(1'b1),
        .xfer_req(xfer_req), .xfer_rd(xfer_rd), .xfer_chan(xfer_chan),
        .xfer_dev(xfer_dev), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
        .busy(busy), .done(done), .buf_en(buf_en)
    );

    function automatic int exp_act(input logic [7:0] t);
        return 17 - int'(t[3:0]);
    endfunction

    function automatic int exp_rec(input logic [7:0] t);
        return (t[7:4] > 4'd13) ? 2 : 15 - int'(t[7:4]);
    endfunction

    function automatic logic [7:0] pick(input logic [7:0] ctl, input logic [7:0] ta,
                                        input logic [7:0] tb, input bit ch, input bit dv);
        bit s;
        s = ctl[0] ? dv : ch;
        return s ? tb : ta;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic xfer(input bit dir, input bit ch, input bit dv,
                        input bit mid_wr, input logic [1:0] mw_a, input logic [7:0] mw_d,
                        input bit poke,
                        output int act, output int rec, output int dcnt,
                        output bit done_last, output bit other_low, output bit busy_after);
        act = 0; rec = 0; dcnt = 0; done_last = 1'b0; other_low = 1'b0;
        @(negedge clk);
        xfer_req = 1'b1; xfer_rd = dir; xfer_chan = ch; xfer_dev = dv;
        @(negedge clk);
        xfer_req = 1'b0;
        while ((dir ? rd_strobe_n : wr_strobe_n) == 1'b0 && act < 40) begin
            if ((dir ? wr_strobe_n : rd_strobe_n) == 1'b0) other_low = 1'b1;
            if (act == 0 && mid_wr) begin
                reg_wr = 1'b1; reg_addr = mw_a; reg_wdata = mw_d;
            end else begin
                reg_wr = 1'b0;
            end
            xfer_req = (act == 0) && poke;
            act++;
            @(negedge clk);
        end
        reg_wr = 1'b0; xfer_req = 1'b0;
        while (busy && rec < 40) begin
            if ((dir ? wr_strobe_n : rd_strobe_n) == 1'b0) other_low = 1'b1;
            if (done) dcnt++;
            done_last = done;
            rec++;
            @(negedge clk);
        end
        @(negedge clk);
        busy_after = busy;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] ta, tb, ct, sel_t;
        int a, r, dc;
        bit dl, ol, ba;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_reg(2'd0, rv); chk("R1 tim_a reset", rv, 8'h00);
        rd_reg(2'd2, rv); chk("R1 tim_b reset", rv, 8'h00);
        rd_reg(2'd3, rv); chk("R1 ctrl reset", rv, 8'h0F);
        chk("R1 idle busy", busy, 0);
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R1 reset active", a, 17);
        chk("R1 reset recovery", r, 15);

        // R3 config readback and write ignored
        rd_reg(2'd1, rv); chk("R3 config", rv, 8'hAD);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, rv); chk("R3 config after write", rv, 8'hAD);
        rd_reg(2'd0, rv); chk("R3 tim_a untouched", rv, 8'h00);
        rd_reg(2'd2, rv); chk("R3 tim_b untouched", rv, 8'h00);
        rd_reg(2'd3, rv); chk("R3 ctrl untouched", rv, 8'h0F);

        // R2 register window
        wr_reg(2'd0, 8'h3C); wr_reg(2'd2, 8'hC3); wr_reg(2'd3, 8'h8E);
        rd_reg(2'd0, rv); chk("R2 tim_a", rv, 8'h3C);
        rd_reg(2'd2, rv); chk("R2 tim_b", rv, 8'hC3);
        rd_reg(2'd3, rv); chk("R2 ctrl", rv, 8'h8E);
        // R10 buffering enable follows control bit 7
        chk("R10 buf_en on", buf_en, 1);
        wr_reg(2'd3, 8'h0F);
        chk("R10 buf_en off", buf_en, 0);

        // R5 clamp of recovery field 14 and 15; R4 boundary active fields
        wr_reg(2'd0, 8'hEF);
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R4 min active", a, 2);
        chk("R5 clamp 14", r, 2);
        chk("R4 write strobe only", ol, 0);
        wr_reg(2'd2, 8'hF0);
        xfer(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R4 max active", a, 17);
        chk("R5 clamp 15", r, 2);
        chk("R4 read strobe only", ol, 0);
        wr_reg(2'd0, 8'hD0);
        xfer(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R5 field 13", r, 2);
        chk("R7 chan ignored", a, 17);

        // R9 mid-cycle write plus R6 request while busy
        wr_reg(2'd0, 8'h00);
        xfer(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h9B, 1'b1, a, r, dc, dl, ol, ba);
        chk("R9 old active kept", a, 17);
        chk("R9 old recovery kept", r, 15);
        chk("R6 done count", dc, 1);
        chk("R6 done on last", dl, 1);
        chk("R6 request while busy ignored", ba, 0);
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R9 new active", a, 6);
        chk("R9 new recovery", r, 6);

        // R8 dual-port mode: channel selects
        wr_reg(2'd0, 8'h21); wr_reg(2'd2, 8'h74); wr_reg(2'd3, 8'h0E);
        xfer(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R8 chan1 active", a, 13);
        chk("R8 chan1 recovery", r, 8);
        xfer(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
        chk("R8 dev ignored active", a, 16);
        chk("R8 dev ignored recovery", r, 13);

        // R4 R5 R7 R8 random mix
        for (int i = 0; i < 60; i++) begin
            bit dir, ch, dv;
            ta = 8'($urandom); tb = 8'($urandom);
            ct = {1'($urandom), 6'b0, 1'($urandom)} | 8'h0E;
            dir = 1'($urandom); ch = 1'($urandom); dv = 1'($urandom);
            wr_reg(2'd0, ta); wr_reg(2'd2, tb); wr_reg(2'd3, ct);
            sel_t = pick(ct, ta, tb, ch, dv);
            xfer(dir, ch, dv, 1'b0, 2'd0, 8'h00, 1'b0, a, r, dc, dl, ol, ba);
            chk(ct[0] ? "R7 random active" : "R8 random active", a, exp_act(sel_t));
            chk("R5 random recovery", r, exp_rec(sel_t));
            chk("R4 random other strobe", ol, 0);
            chk("R10 random buf_en", buf_en, ct[7]);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule